// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core runs one 32-bit instruction to completion in every clock cycle. The program counter addresses an internal instruction store. The fetched word is decoded, its operands are read from a 32 x 32-bit register file, and the ALU works on them. At the next rising edge the core commits a register write or a data-store write, and loads the program counter with the next address. The supported set is small: five register-register operations (add, subtract, and, or, signed set-less-than), add-immediate, word load, word store, branch-if-equal and absolute jump.

The instruction and data stores are word arrays inside the module. A test environment fills them through hierarchical writes before it releases reset. The ports carry the instruction in flight and the writes that it will commit at the coming edge. An external observer can follow execution one instruction per cycle from these ports.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` loads the program counter with 0, and `pc_o` reads 0 in the cycle after a reset edge.
- R2: Fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and funct [5:0]. Opcode 0 with funct 0x20 (add), 0x22 (subtract rs minus rt), 0x24 (and) or 0x25 (or) writes the result to rd.
- R3: Opcode 0 with funct 0x2A writes 1 to rd when rs is less than rt as signed two's-complement numbers. Otherwise it writes 0.
- R4: Opcode 8 writes rs plus the sign-extended immediate [15:0] to rt.
- R5: Opcode 0x23 forms the address rs plus the sign-extended immediate and writes the data word at address bits [DMEM_AW+1:2] to rt.
- R6: Opcode 0x2B writes rt to the data word at that same address and writes no register.
- R7: Opcode 4 compares rs and rt. If they are equal the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4. No register or memory is written.
- R8: Opcode 2 loads the PC with PC[31:28], then the 26-bit field [25:0], then two zero bits.
- R9: A write aimed at register 0 is dropped, so `rf_we_o` stays low. Register 0 always reads as zero.
- R10: An undefined opcode, or opcode 0 with an undefined funct, writes nothing and advances the PC by 4.
- R11: Every instruction other than a taken branch or a jump advances the PC by exactly 4 per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction being executed |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |
| dm_we_o | output | 1 | A data-store write commits at the next edge |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Word to be stored |

## Verification
Each instruction's register write, store and operands appear on the ports during the same cycle that `pc_o` shows it. Their effect becomes visible from the next rising edge: a later instruction that reads the register sees the new value, and `pc_o` shows the next address one cycle later. A reference instruction model in the bench builds the complete expected trace, one entry per cycle, before reset is released. A monitor takes one entry each falling clock edge, so the combinational outputs have settled for the instruction in flight when it compares. The program chains dependent instructions back to back, so a write that landed late or in the wrong place changes a later compared value.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);
  localparam int IWORDS = 2 ** IMEM_AW;
  localparam int DWORDS = 2 ** DMEM_AW;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_e;

  logic [31:0] imem [0:IWORDS-1];
  logic [31:0] dmem [0:DWORDS-1];
  logic [31:0] rf   [0:31];

  logic [31:0] pc_q, pc_next, pc_plus4;
  logic [31:0] instr;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, dest;
  logic [31:0] sext, rs_val, rt_val, src_b, alu_y;
  logic        is_r, is_lw, is_sw, is_addi, is_beq, is_j, r_ok, zero, wen;
  alu_e        alu_op;
  logic        unused;

  assign instr   = imem[pc_q[IMEM_AW+1:2]];
  assign op      = instr[31:26];
  assign rs      = instr[25:21];
  assign rt      = instr[20:16];
  assign rd      = instr[15:11];
  assign funct   = instr[5:0];
  assign sext    = {{16{instr[15]}}, instr[15:0]};
  assign unused  = ^instr[10:6];

  assign is_r    = (op == OP_RTYPE);
  assign is_lw   = (op == OP_LW);
  assign is_sw   = (op == OP_SW);
  assign is_addi = (op == OP_ADDI);
  assign is_beq  = (op == OP_BEQ);
  assign is_j    = (op == OP_JMP);

  always_comb begin
    alu_op = ALU_ADD;
    r_ok   = 1'b0;
    if (is_r) begin
      case (funct)
        FN_ADD: begin alu_op = ALU_ADD; r_ok = 1'b1; end
        FN_SUB: begin alu_op = ALU_SUB; r_ok = 1'b1; end
        FN_AND: begin alu_op = ALU_AND; r_ok = 1'b1; end
        FN_OR:  begin alu_op = ALU_OR;  r_ok = 1'b1; end
        FN_SLT: begin alu_op = ALU_SLT; r_ok = 1'b1; end
        default: ;
      endcase
    end else if (is_beq) begin
      alu_op = ALU_SUB;
    end
  end

  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign src_b  = (is_lw || is_sw || is_addi) ? sext : rt_val;

  always_comb begin
    case (alu_op)
      ALU_SUB: alu_y = rs_val - src_b;
      ALU_AND: alu_y = rs_val & src_b;
      ALU_OR:  alu_y = rs_val | src_b;
      ALU_SLT: alu_y = {31'd0, ($signed(rs_val) < $signed(src_b))};
      default: alu_y = rs_val + src_b;
    endcase
  end
  assign zero = (alu_y == 32'd0);

  assign dest = is_r ? rd : rt;
  assign wen  = ((is_r && r_ok) || is_lw || is_addi) && (dest != 5'd0);

  assign pc_plus4 = pc_q + 32'd4;
  always_comb begin
    if (is_j)
      pc_next = {pc_q[31:28], instr[25:0], 2'b00};
    else if (is_beq && zero)
      pc_next = pc_plus4 + {sext[29:0], 2'b00};
    else
      pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= 32'd0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (!rst && wen) rf[dest] <= rf_wdata_o;
    if (!rst && is_sw) dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
  end

  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = wen;
  assign rf_waddr_o = dest;
  assign rf_wdata_o = is_lw ? dmem[alu_y[DMEM_AW+1:2]] : alu_y;
  assign dm_we_o    = is_sw;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc_q == 32'd0)); // R1
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (!is_j && !(is_beq && zero)) |=> (pc_q == $past(pc_q) + 32'd4)); // R11
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (is_beq && (rs_val == rt_val)) |=> (pc_q == $past(pc_q) + 32'd4 + {$past(sext[29:0]), 2'b00})); // R7
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    is_j |=> (pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00})); // R8
  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_waddr_o != 5'd0)); // R9
  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> !rf_we_o); // R6
  AST_BEQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    is_beq |-> (!rf_we_o && !dm_we_o)); // R7
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int IAW = 8;
  localparam int DAW = 8;
  localparam int NCYC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  sc_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u0 (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr_o(instr_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o));

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] pc;
    logic        rwe;
    logic [4:0]  ra;
    logic [31:0] rd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] md;
    logic [31:0] ins;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] prog [0:2**IAW-1];
  logic [31:0] mem  [0:2**DAW-1];
  logic [31:0] regs [0:31];
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] o, int s, int t, int imm);
    return {o, 5'(s), 5'(t), 16'(imm)};
  endfunction

  function automatic string tag_of(logic [31:0] w);
    case (w[31:26])
      6'h00: return (w[5:0] == 6'h2A) ? "R3" :
                    (w[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25}) ? "R2" : "R10";
      6'h08: return "R4";
      6'h23: return "R5";
      6'h2B: return "R6";
      6'h04: return "R7";
      6'h02: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic build_trace();
    logic [31:0] pc = 32'd0;
    for (int c = 0; c < NCYC; c++) begin
      exp_t e;
      logic [31:0] w, a, b, im, res, nx;
      logic [4:0] dst;
      logic wr;
      w  = prog[pc[IAW+1:2]];
      a  = regs[w[25:21]];
      b  = regs[w[20:16]];
      im = {{16{w[15]}}, w[15:0]};
      nx = pc + 32'd4;
      wr = 1'b0; dst = w[20:16]; res = 32'd0;
      e.pc = pc; e.ins = w; e.mwe = 1'b0; e.ma = 32'd0; e.md = 32'd0;
      case (w[31:26])
        6'h00: begin
          dst = w[15:11]; wr = 1'b1;
          case (w[5:0])
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: wr = 1'b0;
          endcase
        end
        6'h08: begin wr = 1'b1; res = a + im; end
        6'h23: begin wr = 1'b1; res = mem[(a + im) >> 2]; end
        6'h2B: begin e.mwe = 1'b1; e.ma = a + im; e.md = b; end
        6'h04: if (a == b) nx = pc + 32'd4 + (im << 2);
        6'h02: nx = {pc[31:28], w[25:0], 2'b00};
        default: ;
      endcase
      if (dst == 5'd0) wr = 1'b0;
      e.rwe = wr; e.ra = dst; e.rd = res;
      if (wr) regs[dst] = res;
      if (e.mwe) mem[e.ma[DAW+1:2]] = e.md;
      sb.push_back(e);
      pc = nx;
    end
  endtask

  task automatic note(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 2**IAW; i++) prog[i] = 32'd0;
    for (int i = 0; i < 2**DAW; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) regs[i] = 32'd0;
    mem[2] = 32'hDEAD_BEEF;
    prog[0]  = enc_i(6'h08, 0, 1, 5);
    prog[1]  = enc_i(6'h08, 0, 2, -3);
    prog[2]  = enc_r(1, 2, 3, 6'h20);
    prog[3]  = enc_r(2, 1, 4, 6'h22);
    prog[4]  = enc_r(1, 2, 5, 6'h24);
    prog[5]  = enc_r(1, 2, 6, 6'h25);
    prog[6]  = enc_r(2, 1, 7, 6'h2A);
    prog[7]  = enc_r(1, 2, 8, 6'h2A);
    prog[8]  = enc_i(6'h08, 1, 0, 7);
    prog[9]  = enc_r(0, 0, 9, 6'h20);
    prog[10] = enc_i(6'h23, 0, 10, 8);
    prog[11] = enc_i(6'h2B, 0, 4, 16);
    prog[12] = enc_i(6'h23, 0, 11, 16);
    prog[13] = enc_i(6'h08, 0, 12, 3);
    prog[14] = enc_i(6'h08, 12, 12, -1);
    prog[15] = enc_i(6'h04, 12, 0, 1);
    prog[16] = enc_i(6'h04, 0, 0, -3);
    prog[17] = 32'hFC00_0000;
    prog[18] = enc_r(1, 2, 13, 6'h3F);
    prog[19] = {6'h02, 26'd21};
    prog[20] = enc_i(6'h08, 0, 13, 99);
    prog[21] = {6'h02, 26'd21};
    for (int i = 0; i < 2**IAW; i++) u0.imem[i] = prog[i];
    for (int i = 0; i < 2**DAW; i++) u0.dmem[i] = mem[i];
    build_trace();
  end

  initial begin
    exp_t e;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    note(pc_o == 32'd0, "R1", "pc after reset", pc_o, 32'd0);
    rst = 1'b0;
    for (int c = 0; c < NCYC; c++) begin
      string t;
      e = sb.pop_front();
      t = tag_of(e.ins);
      note(pc_o == e.pc, (e.ins[31:26] == 6'h04) ? "R7" : "R11", "pc", pc_o, e.pc);
      note(rf_we_o == e.rwe, (e.ra == 5'd0 && e.ins[31:26] != 6'h2B) ? "R9" : t,
           "reg write enable", 32'(rf_we_o), 32'(e.rwe));
      if (e.rwe) begin
        note(rf_waddr_o == e.ra, t, "reg dest", 32'(rf_waddr_o), 32'(e.ra));
        note(rf_wdata_o == e.rd, t, "reg data", rf_wdata_o, e.rd);
      end
      note(dm_we_o == e.mwe, t, "store enable", 32'(dm_we_o), 32'(e.mwe));
      if (e.mwe) begin
        note(dm_addr_o == e.ma, "R6", "store addr", dm_addr_o, e.ma);
        note(dm_wdata_o == e.md, "R6", "store data", dm_wdata_o, e.md);
      end
      @(negedge clk);
    end
    rst = 1'b1;
    @(negedge clk);
    note(pc_o == 32'd0, "R1", "pc after mid-run reset", pc_o, 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL R11 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule